// File: doc/BRIEF.md
# Frequent-Value Word Codec

This block squeezes memory words into short code words by looking them up in a small table of commonly seen values. An encode request presents one N-bit word. The table is searched by content. If a valid entry holds that word, the block returns the entry's K-bit index as the code, and a per-word flag marks the slot as encoded. If no valid entry holds it, the word goes out unchanged in the full N-bit data region, and the flag marks the slot as raw. The table holds 2^K entries, so the code width sets the table depth.

A decode request presents a stored slot and the written bit of the row the slot came from. If the row has not been written since it was filled from backing storage, the data region is returned as it is and the table lookup stays idle. The same happens when the slot's flag says raw. In every other case the code indexes the value array and the stored value is returned. Software or a training engine loads the table through a plain write port. Table writes take priority over both request ports.

Each port has a valid/ready handshake. Its result is registered and appears one cycle after the request is accepted.

Top module: `fv_codec`

## Requirements
- R1: After reset, both result-valid outputs are 0 and every table entry is invalid, so the first encode of any word yields a raw slot.
- R2: An encode hit yields a slot of width N+1. Bit N holds the flag, which is 0. Bits K-1..0 hold the matching index, and bits N-1..K are 0.
- R3: An encode miss yields flag bit N = 1 with bits N-1..0 equal to the input word.
- R4: A table entry written with its valid input at 0 never produces an encode hit, even when its value matches.
- R5: When several valid entries hold the encoded word, the lowest index is returned as the code.
- R6: A decode of a slot with flag 0 from a row whose written bit is 1 returns the table value stored at index bits K-1..0, and drives the table-lookup indicator high in the result cycle.
- R7: A decode of a slot with flag 1 returns bits N-1..0 unchanged, with the table-lookup indicator low.
- R8: A decode with the row written bit at 0 returns bits N-1..0 unchanged whatever the flag, with the table-lookup indicator low.
- R9: A result-valid output is high in the cycle after an accepted request, and only then.
- R10: While a table write is presented, both ready outputs are 0 and no request is accepted. A written entry takes effect for requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | CODE_W | Entry index to write |
| tblWrVal | input | DATA_W | Value to store in the entry |
| tblWrValid | input | 1 | Valid bit to store in the entry |
| encValid | input | 1 | Encode request valid |
| encReady | output | 1 | Encode request accepted when high |
| encWord | input | DATA_W | Word to encode |
| encOutValid | output | 1 | Encode result valid |
| encOutSlot | output | DATA_W+1 | Encoded slot {flag, data region} |
| decValid | input | 1 | Decode request valid |
| decReady | output | 1 | Decode request accepted when high |
| decSlot | input | DATA_W+1 | Stored slot {flag, data region} |
| decRowWritten | input | 1 | Written bit of the slot's row |
| decOutValid | output | 1 | Decode result valid |
| decOutWord | output | DATA_W | Decoded word |
| decLookup | output | 1 | High when the result came from a table lookup |

## Verification
The hardest case to reach from the ports is a word that matches more than one entry, where one of the matching entries is marked invalid. The bench writes the same value into several entries, with the lowest of them marked invalid. It then checks that the first valid duplicate wins. Table-write collisions are reached by raising the write strobe in the same cycle as both request valids. The bench confirms that no result appears, and that the new entry is used by the next encode.

// File: rtl/fv_codec_pkg.sv
package fv_codec_pkg;
  typedef struct packed {
    logic tblWrite;
    logic encLoad;
    logic decLoad;
    logic decUseTable;
  } strobe_t;
endpackage

// File: rtl/fv_codec_ctrl.sv
module fv_codec_ctrl
  import fv_codec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tblWrEn,
  input  logic              encValid,
  input  logic              decValid,
  input  logic              decFlag,
  input  logic              decRowWritten,
  output logic              encReady,
  output logic              decReady,
  output logic              encOutValid,
  output logic              decOutValid,
  output logic              decLookup,
  output strobe_t           strobes
);
  // Table writes win over both request ports
  always_comb begin
    encReady            = !tblWrEn;
    decReady            = !tblWrEn;
    strobes.tblWrite    = tblWrEn;
    strobes.encLoad     = encValid && !tblWrEn;
    strobes.decLoad     = decValid && !tblWrEn;
    strobes.decUseTable = !decFlag && decRowWritten;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
      decLookup   <= 1'b0;
    end else begin
      encOutValid <= strobes.encLoad;
      decOutValid <= strobes.decLoad;
      decLookup   <= strobes.decLoad && strobes.decUseTable;
    end
  end
endmodule

// File: rtl/fv_codec_dp.sv
module fv_codec_dp
  import fv_codec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [CODE_W-1:0] tblWrIdx,
  input  logic [DATA_W-1:0] tblWrVal,
  input  logic              tblWrValid,
  input  logic [DATA_W-1:0] encWord,
  input  logic [DATA_W-1:0] decData,
  output logic [DATA_W:0]   encOutSlot,
  output logic [DATA_W-1:0] decOutWord
);
  localparam int DEPTH = 1 << CODE_W;
  localparam int PAD_W = DATA_W - CODE_W;

  logic [DATA_W-1:0] entryVal   [DEPTH];
  logic [DEPTH-1:0]  entryValid;
  logic [DEPTH-1:0]  matchVec;
  logic [CODE_W-1:0] hitIdx;
  logic              hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign matchVec[i] = entryValid[i] && (entryVal[i] == encWord);
  end

  // Lowest matching index wins
  always_comb begin
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = CODE_W'(i);
    end
    hit = |matchVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entryValid <= '0;
      for (int i = 0; i < DEPTH; i++) entryVal[i] <= '0;
      encOutSlot <= '0;
      decOutWord <= '0;
    end else begin
      if (strobes.tblWrite) begin
        entryVal[tblWrIdx]   <= tblWrVal;
        entryValid[tblWrIdx] <= tblWrValid;
      end
      if (strobes.encLoad) begin
        encOutSlot <= hit ? {1'b0, {PAD_W{1'b0}}, hitIdx} : {1'b1, encWord};
      end
      if (strobes.decLoad) begin
        decOutWord <= strobes.decUseTable ? entryVal[decData[CODE_W-1:0]] : decData;
      end
    end
  end
endmodule

// File: rtl/fv_codec.sv
module fv_codec
  import fv_codec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tblWrEn,
  input  logic [CODE_W-1:0] tblWrIdx,
  input  logic [DATA_W-1:0] tblWrVal,
  input  logic              tblWrValid,
  input  logic              encValid,
  output logic              encReady,
  input  logic [DATA_W-1:0] encWord,
  output logic              encOutValid,
  output logic [DATA_W:0]   encOutSlot,
  input  logic              decValid,
  output logic              decReady,
  input  logic [DATA_W:0]   decSlot,
  input  logic              decRowWritten,
  output logic              decOutValid,
  output logic [DATA_W-1:0] decOutWord,
  output logic              decLookup
);
  strobe_t strobes;

  fv_codec_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tblWrEn(tblWrEn),
    .encValid(encValid), .decValid(decValid),
    .decFlag(decSlot[DATA_W]), .decRowWritten(decRowWritten),
    .encReady(encReady), .decReady(decReady),
    .encOutValid(encOutValid), .decOutValid(decOutValid),
    .decLookup(decLookup), .strobes(strobes)
  );

  fv_codec_dp #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .tblWrIdx(tblWrIdx), .tblWrVal(tblWrVal), .tblWrValid(tblWrValid),
    .encWord(encWord), .decData(decSlot[DATA_W-1:0]),
    .encOutSlot(encOutSlot), .decOutWord(decOutWord)
  );
endmodule

// File: rtl/fv_codec_chk.sv
module fv_codec_chk #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tblWrEn,
  input logic              encValid,
  input logic              encReady,
  input logic [DATA_W-1:0] encWord,
  input logic              encOutValid,
  input logic [DATA_W:0]   encOutSlot,
  input logic              decValid,
  input logic              decReady,
  input logic [DATA_W:0]   decSlot,
  input logic              decRowWritten,
  input logic              decOutValid,
  input logic [DATA_W-1:0] decOutWord,
  input logic              decLookup
);
  AST_ENC_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (encValid && encReady) |=> encOutValid); // R9
  AST_ENC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(encValid && encReady) |=> !encOutValid); // R9
  AST_DEC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(decValid && decReady) |=> !decOutValid); // R9
  AST_WRITE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tblWrEn |=> (!encOutValid && !decOutValid)); // R10
  AST_HIT_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
    (encOutValid && !encOutSlot[DATA_W]) |-> (encOutSlot[DATA_W-1:CODE_W] == '0)); // R2
  AST_MISS_RAW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (encValid && encReady) |=> (!encOutSlot[DATA_W] || encOutSlot[DATA_W-1:0] == $past(encWord))); // R3
  AST_RAW_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && decReady && decSlot[DATA_W]) |=>
      (!decLookup && decOutWord == $past(decSlot[DATA_W-1:0]))); // R7
  AST_UNWRITTEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && decReady && !decRowWritten) |=>
      (!decLookup && decOutWord == $past(decSlot[DATA_W-1:0]))); // R8
  AST_LOOKUP_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && decReady && !decSlot[DATA_W] && decRowWritten) |=> decLookup); // R6
endmodule

bind fv_codec fv_codec_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tblWrEn(tblWrEn),
  .encValid(encValid), .encReady(encReady), .encWord(encWord),
  .encOutValid(encOutValid), .encOutSlot(encOutSlot),
  .decValid(decValid), .decReady(decReady), .decSlot(decSlot),
  .decRowWritten(decRowWritten), .decOutValid(decOutValid),
  .decOutWord(decOutWord), .decLookup(decLookup)
);

// File: tb/fv_codec_test.sv
module fv_codec_test;
  localparam int DATA_W = 32;
  localparam int CODE_W = 3;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tblWrEn = 1'b0;
  logic [CODE_W-1:0] tblWrIdx = '0;
  logic [DATA_W-1:0] tblWrVal = '0;
  logic              tblWrValid = 1'b0;
  logic              encValid = 1'b0;
  logic              encReady;
  logic [DATA_W-1:0] encWord = '0;
  logic              encOutValid;
  logic [DATA_W:0]   encOutSlot;
  logic              decValid = 1'b0;
  logic              decReady;
  logic [DATA_W:0]   decSlot = '0;
  logic              decRowWritten = 1'b0;
  logic              decOutValid;
  logic [DATA_W-1:0] decOutWord;
  logic              decLookup;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fv_codec #(.DATA_W(DATA_W), .CODE_W(CODE_W)) uut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic [DATA_W-1:0] val, input bit vld);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = CODE_W'(idx); tblWrVal = val; tblWrValid = vld;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic encode(input logic [DATA_W-1:0] w, output logic [DATA_W:0] slot, output bit vld);
    @(negedge clk);
    encValid = 1'b1; encWord = w;
    @(posedge clk); #1;
    slot = encOutSlot; vld = encOutValid;
    encValid = 1'b0;
  endtask

  task automatic decode(input logic [DATA_W:0] s, input bit rw,
                        output logic [DATA_W-1:0] w, output bit lk, output bit vld);
    @(negedge clk);
    decValid = 1'b1; decSlot = s; decRowWritten = rw;
    @(posedge clk); #1;
    w = decOutWord; lk = decLookup; vld = decOutValid;
    decValid = 1'b0;
  endtask

  task automatic testReset();
    logic [DATA_W:0] s; bit v;
    check(encOutValid == 1'b0, "R1 enc valid at reset", 64'(encOutValid), 0);
    check(decOutValid == 1'b0, "R1 dec valid at reset", 64'(decOutValid), 0);
    encode(32'h0, s, v);
    check(s == {1'b1, 32'h0}, "R1 empty table gives raw", 64'(s), 64'({1'b1, 32'h0}));
  endtask

  task automatic testEncode();
    logic [DATA_W:0] s; bit v;
    encode(32'h0, s, v);
    check(v && s == 33'h0_0000_0000, "R2 hit index 0", 64'(s), 0);
    encode(32'hFFFF_FFFF, s, v);
    check(v && s == 33'h0_0000_0005, "R2 hit index 5", 64'(s), 5);
    encode(32'hABCD_0123, s, v);
    check(v && s == {1'b1, 32'hABCD_0123}, "R3 miss raw", 64'(s), 64'({1'b1, 32'hABCD_0123}));
  endtask

  task automatic testInvalidEntry();
    logic [DATA_W:0] s; bit v;
    encode(32'h1234_5678, s, v);
    check(s == {1'b1, 32'h1234_5678}, "R4 invalid entry no hit", 64'(s), 64'({1'b1, 32'h1234_5678}));
  endtask

  task automatic testPriority();
    logic [DATA_W:0] s; bit v;
    encode(32'hDEAD_BEEF, s, v);
    check(s == 33'h0_0000_0002, "R5 lowest valid duplicate", 64'(s), 2);
  endtask

  task automatic testDecode();
    logic [DATA_W-1:0] w; bit lk; bit v;
    decode(33'h0_0000_0002, 1'b1, w, lk, v);
    check(v && w == 32'hDEAD_BEEF && lk, "R6 table lookup", 64'(w), 64'h0DEAD_BEEF);
    decode(33'h0_0000_0005, 1'b1, w, lk, v);
    check(w == 32'hFFFF_FFFF && lk, "R6 table lookup idx5", 64'(w), 64'hFFFF_FFFF);
    decode({1'b1, 32'h5555_AAAA}, 1'b1, w, lk, v);
    check(v && w == 32'h5555_AAAA && !lk, "R7 raw bypass", 64'({lk, w}), 64'h5555_AAAA);
    decode(33'h0_0000_0002, 1'b0, w, lk, v);
    check(v && w == 32'h0000_0002 && !lk, "R8 unwritten row bypass", 64'({lk, w}), 64'h2);
    decode({1'b1, 32'h0BAD_F00D}, 1'b0, w, lk, v);
    check(w == 32'h0BAD_F00D && !lk, "R8 unwritten raw", 64'({lk, w}), 64'h0BAD_F00D);
  endtask

  task automatic testLatency();
    logic [DATA_W:0] s; bit v;
    encode(32'h1, s, v);
    check(v == 1'b1, "R9 result next cycle", 64'(v), 1);
    @(posedge clk); #1;
    check(encOutValid == 1'b0, "R9 no result when idle", 64'(encOutValid), 0);
    check(decOutValid == 1'b0, "R9 dec idle", 64'(decOutValid), 0);
  endtask

  task automatic testWriteStall();
    logic [DATA_W:0] s; bit v;
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = 3'd6; tblWrVal = 32'hCAFE_0000; tblWrValid = 1'b1;
    encValid = 1'b1; encWord = 32'hCAFE_0000;
    decValid = 1'b1; decSlot = 33'h0; decRowWritten = 1'b1;
    #1;
    check(!encReady && !decReady, "R10 ready low on write", 64'({encReady, decReady}), 0);
    @(posedge clk); #1;
    check(!encOutValid && !decOutValid, "R10 nothing accepted", 64'({encOutValid, decOutValid}), 0);
    tblWrEn = 1'b0; encValid = 1'b0; decValid = 1'b0;
    encode(32'hCAFE_0000, s, v);
    check(v && s == 33'h0_0000_0006, "R10 new entry used", 64'(s), 6);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    writeEntry(0, 32'h0, 1'b1);
    writeEntry(1, 32'hDEAD_BEEF, 1'b0);
    writeEntry(2, 32'hDEAD_BEEF, 1'b1);
    writeEntry(3, 32'hDEAD_BEEF, 1'b1);
    writeEntry(4, 32'h1234_5678, 1'b0);
    writeEntry(5, 32'hFFFF_FFFF, 1'b1);
    testEncode();
    testInvalidEntry();
    testPriority();
    testDecode();
    testLatency();
    testWriteStall();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule